// File: doc/BRIEF.md
# Zero-Page and Stack Register-File Router

This block sits between an 8-bit CPU core with a 16-bit address and its main memory. It inspects the page number of every access, which is the upper address byte. Page 0 and page 1 are served from two internal 256-byte register arrays. Those arrays answer a read combinationally, in the cycle the read is issued. Every other page goes out on a synchronous RAM port, and the read data for those pages comes back one clock later. A ready output tells the CPU whether the data on the read bus is valid in the current cycle.

The block also forms stack addresses. When the stack-select input is high, the full address input is ignored. The effective address becomes page 1 with the 8-bit stack pointer as its low byte.

A clear request wipes both arrays to zero, one entry per cycle, while busy is high. Reset leaves the arrays untouched.

Top module: `zpstk_router`

## Requirements
- R1: With `stack_sel` high, the effective address is 0x01 concatenated with `stack_ptr`, and `cpu_addr` is ignored. A byte written through the stack path reads back through `cpu_addr` = 0x0100 + `stack_ptr`.
- R2: A read to 0x0000–0x00FF returns the page-0 array byte on `cpu_rdata` with `rd_ready` high in the same cycle.
- R3: A read to 0x0100–0x01FF returns the page-1 array byte in the same cycle. Page 1 and page 0 are separate storage, so equal low bytes do not alias.
- R4: An access to 0x0200–0xFFFF drives `ram_en` high and puts the effective address on `ram_addr`. A write also drives `ram_we` high and puts the data on `ram_wdata`. A read keeps `rd_ready` low in its own cycle and raises it in the next cycle, with `cpu_rdata` equal to `ram_rdata`.
- R5: `ram_en` is never high for an effective address in 0x0000–0x01FF, and 0x01FF/0x0200 fall on opposite sides of that split.
- R6: A write to an array takes effect at the rising edge, so a read of the same address in the next cycle returns the new byte.
- R7: `clr_req` sampled high while idle raises `busy` for exactly 256 cycles, after which every entry of both arrays reads as zero.
- R8: While `busy` is high, CPU accesses are dropped: `ram_en` stays low, `rd_ready` stays low for new reads, and array writes have no effect.
- R9: Reset clears `busy` and any pending RAM read but does not change array contents.
- R10: `rd_ready` is low in any cycle with no read issued and no RAM read returning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Full address from the CPU |
| stack_sel | input | 1 | Use the stack-pointer address path |
| stack_ptr | input | 8 | Stack pointer, low byte of a page-1 address |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request (wins over `cpu_rd`) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data |
| rd_ready | output | 1 | Read data on `cpu_rdata` is valid this cycle |
| clr_req | input | 1 | Start zeroing both arrays |
| busy | output | 1 | Array clear in progress |
| ram_en | output | 1 | Main RAM access enable |
| ram_we | output | 1 | Main RAM write enable |
| ram_addr | output | 16 | Main RAM address |
| ram_wdata | output | 8 | Main RAM write data |
| ram_rdata | input | 8 | Main RAM read data, one cycle after the read |

## Verification
The hardest case to reach from the ports is a CPU write that lands in the middle of the clear window. That write targets an entry the sweep has already zeroed, so a leak would survive to the end of the clear. The stimulus counts busy cycles at the ports and injects an array write and a RAM read at a fixed cycle deep inside the sweep. After busy falls, it reads the written address back. Reset retention is reached the same way: the bench pulses reset between a write and its readback.

// File: rtl/zpstk_pkg.sv
package zpstk_pkg;
  localparam int ZS_ADDR_W = 16;
  localparam int ZS_DATA_W = 8;
  localparam int ZS_OFF_W  = 8;
  localparam int ZERO_PAGE  = 0;
  localparam int STACK_PAGE = 1;

  typedef enum logic [1:0] {
    PG_ZERO  = 2'd0,
    PG_STACK = 2'd1,
    PG_RAM   = 2'd2
  } page_sel_e;
endpackage

// File: rtl/zpstk_regfile.sv
module zpstk_regfile #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [OFF_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [OFF_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << OFF_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // no reset: contents survive rst_n
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/zpstk_clear_seq.sv
module zpstk_clear_seq #(
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [OFF_W-1:0] idx
);
  logic last_entry;
  assign last_entry = &idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end else begin
      idx <= idx + 1'b1;
      if (last_entry) busy <= 1'b0;
    end
  end

  AST_CLEAR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_entry) |=> !busy); // R7
  AST_CLEAR_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (idx == '0)); // R7
endmodule

// File: rtl/zpstk_router.sv
module zpstk_router
  import zpstk_pkg::*;
#(
  parameter int ADDR_W = ZS_ADDR_W,
  parameter int DATA_W = ZS_DATA_W,
  parameter int OFF_W  = ZS_OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              stack_sel,
  input  logic [OFF_W-1:0]  stack_ptr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              rd_ready,
  input  logic              clr_req,
  output logic              busy,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int N_ARR  = 2;

  function automatic logic [ADDR_W-1:0] stack_addr(input logic [OFF_W-1:0] sp);
    return {PAGE_W'(STACK_PAGE), sp};
  endfunction

  function automatic page_sel_e page_of(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] pg;
    pg = a[ADDR_W-1:OFF_W];
    if (pg == PAGE_W'(ZERO_PAGE))       return PG_ZERO;
    else if (pg == PAGE_W'(STACK_PAGE)) return PG_STACK;
    else                                return PG_RAM;
  endfunction

  // effective address and page decision
  logic [ADDR_W-1:0] eff_addr;
  page_sel_e         eff_page;
  logic              clr_busy;
  logic [OFF_W-1:0]  clr_idx;
  logic              acc_ok;

  assign eff_addr = stack_sel ? stack_addr(stack_ptr) : cpu_addr;
  assign eff_page = page_of(eff_addr);
  assign acc_ok   = !clr_busy;

  logic [N_ARR-1:0]  arr_hit;
  logic              ram_hit;
  assign arr_hit[0] = acc_ok && (eff_page == PG_ZERO);
  assign arr_hit[1] = acc_ok && (eff_page == PG_STACK);
  assign ram_hit    = acc_ok && (eff_page == PG_RAM);

  // named events
  logic ram_rd_issue;
  logic arr_rd_now;
  logic ram_pend_q;
  assign ram_rd_issue = ram_hit && cpu_rd && !cpu_wr;
  assign arr_rd_now   = (|arr_hit) && cpu_rd && !cpu_wr;

  // main RAM port
  assign ram_en    = ram_hit && (cpu_rd || cpu_wr);
  assign ram_we    = ram_hit && cpu_wr;
  assign ram_addr  = eff_addr;
  assign ram_wdata = cpu_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) ram_pend_q <= 1'b0;
    else        ram_pend_q <= ram_rd_issue;
  end

  // clear sweep
  zpstk_clear_seq #(.OFF_W(OFF_W)) u_clear (
    .clk   (clk),
    .rst_n (rst_n),
    .start (clr_req),
    .busy  (clr_busy),
    .idx   (clr_idx)
  );
  assign busy = clr_busy;

  // two page arrays
  logic [DATA_W-1:0] arr_rdata [N_ARR];

  for (genvar g = 0; g < N_ARR; g++) begin : g_arr
    logic              a_we;
    logic [OFF_W-1:0]  a_waddr;
    logic [DATA_W-1:0] a_wdata;
    assign a_we    = clr_busy || (arr_hit[g] && cpu_wr);
    assign a_waddr = clr_busy ? clr_idx : eff_addr[OFF_W-1:0];
    assign a_wdata = clr_busy ? '0 : cpu_wdata;
    zpstk_regfile #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_rf (
      .clk   (clk),
      .we    (a_we),
      .waddr (a_waddr),
      .wdata (a_wdata),
      .raddr (eff_addr[OFF_W-1:0]),
      .rdata (arr_rdata[g])
    );
  end

  // output mux: a returning RAM read takes the bus
  assign rd_ready  = ram_pend_q || arr_rd_now;
  assign cpu_rdata = ram_pend_q ? ram_rdata :
                     arr_hit[1] ? arr_rdata[1] : arr_rdata[0];

  AST_RAM_LOW_PAGES: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (ram_addr[ADDR_W-1:OFF_W+1] != '0)); // R5
  AST_STACK_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    stack_sel |-> !ram_en); // R3
  AST_RAM_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !ram_we) |=> rd_ready); // R4
  AST_ARR_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr && !busy && ram_addr[ADDR_W-1:OFF_W+1] == '0) |-> rd_ready); // R2
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ram_en); // R8
  AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rd && !$past(ram_en && !ram_we)) |-> !rd_ready); // R10
endmodule

// File: tb/zpstk_router_bench.sv
module zpstk_router_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        stack_sel;
  logic [7:0]  stack_ptr;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        rd_ready, clr_req, busy;
  logic        ram_en, ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zpstk_router u_zpstk_router (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .stack_sel(stack_sel),
    .stack_ptr(stack_ptr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rd_ready(rd_ready),
    .clr_req(clr_req), .busy(busy), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // one-cycle synchronous RAM model
  logic [7:0] bmem [1024];
  always_ff @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) bmem[ram_addr[9:0]] <= ram_wdata;
      else        ram_rdata <= bmem[ram_addr[9:0]];
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_addr = '0; stack_sel = 0; stack_ptr = '0;
    cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0; clr_req = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); idle(); cpu_addr = a; cpu_wr = 1; cpu_wdata = d;
  endtask

  // array read: data in the same cycle
  task automatic rd_arr(input string req, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk); idle(); cpu_addr = a; cpu_rd = 1; #1;
    chk(req, {15'd0, rd_ready}, 16'd1);
    chk(req, {8'd0, cpu_rdata}, {8'd0, exp});
    chk(req, {15'd0, ram_en}, 16'd0);
  endtask

  task automatic t_reset();
    idle(); rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 busy in reset", {15'd0, busy}, 16'd0);
    chk("R10 ready in reset", {15'd0, rd_ready}, 16'd0);
    rst_n = 1;
  endtask

  task automatic t_zero_page();
    wr(16'h0012, 8'hA5);
    rd_arr("R6 page0 write visible", 16'h0012, 8'hA5);
    wr(16'h0012, 8'h3C);
    rd_arr("R2 page0 read", 16'h0012, 8'h3C);
    wr(16'h0034, 8'h11);
    @(negedge clk); idle(); #1;
    chk("R10 idle not ready", {15'd0, rd_ready}, 16'd0);
  endtask

  task automatic t_stack();
    @(negedge clk); idle();
    stack_sel = 1; stack_ptr = 8'h34; cpu_addr = 16'h0234;
    cpu_wr = 1; cpu_wdata = 8'h77; #1;
    chk("R3 stack write no RAM", {15'd0, ram_en}, 16'd0);
    rd_arr("R1 stack via full address", 16'h0134, 8'h77);
    rd_arr("R3 pages do not alias", 16'h0034, 8'h11);
    @(negedge clk); idle();
    stack_sel = 1; stack_ptr = 8'h34; cpu_addr = 16'h0012; cpu_rd = 1; #1;
    chk("R1 stack read path", {8'd0, cpu_rdata}, 16'h0077);
    chk("R3 stack read ready", {15'd0, rd_ready}, 16'd1);
  endtask

  task automatic t_ram();
    @(negedge clk); idle(); cpu_addr = 16'h0234; cpu_wr = 1; cpu_wdata = 8'h5A; #1;
    chk("R4 ram write en", {14'd0, ram_en, ram_we}, 16'd3);
    chk("R4 ram addr", ram_addr, 16'h0234);
    chk("R4 ram wdata", {8'd0, ram_wdata}, 16'h005A);
    wr(16'hFF80, 8'hC3);
    @(negedge clk); idle(); cpu_addr = 16'h0234; cpu_rd = 1; #1;
    chk("R4 ram read en", {14'd0, ram_en, ram_we}, 16'd2);
    chk("R4 not ready same cycle", {15'd0, rd_ready}, 16'd0);
    @(negedge clk); idle(); #1;
    chk("R4 ready next cycle", {15'd0, rd_ready}, 16'd1);
    chk("R4 ram data", {8'd0, cpu_rdata}, 16'h005A);
    @(negedge clk); idle(); cpu_addr = 16'hFF80; cpu_rd = 1;
    @(negedge clk); idle(); #1;
    chk("R4 high page data", {8'd0, cpu_rdata}, 16'h00C3);
    wr(16'h01FF, 8'h42);
    #1 chk("R5 0x01FF no RAM", {15'd0, ram_en}, 16'd0);
    rd_arr("R5 0x01FF from array", 16'h01FF, 8'h42);
    @(negedge clk); idle(); cpu_addr = 16'h0200; cpu_rd = 1; #1;
    chk("R5 0x0200 uses RAM", {15'd0, ram_en}, 16'd1);
  endtask

  task automatic t_reset_keep();
    wr(16'h0040, 8'h99);
    @(negedge clk); idle(); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_arr("R9 array kept over reset", 16'h0040, 8'h99);
  endtask

  task automatic t_clear();
    int cnt;
    cnt = 0;
    @(negedge clk); idle(); clr_req = 1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); idle(); #1;
      if (busy) begin
        cnt++;
        if (cnt == 100) begin
          cpu_addr = 16'h0005; cpu_wr = 1; cpu_wdata = 8'hEE; #1;
          chk("R8 write during busy no RAM", {15'd0, ram_en}, 16'd0);
        end else if (cnt == 101) begin
          cpu_addr = 16'h0234; cpu_rd = 1; #1;
          chk("R8 read during busy no RAM", {15'd0, ram_en}, 16'd0);
          chk("R8 read during busy not ready", {15'd0, rd_ready}, 16'd0);
        end
      end else if (cnt > 0) begin
        break;
      end
    end
    chk("R7 busy length", 16'(cnt), 16'd256);
    rd_arr("R8 busy write dropped", 16'h0005, 8'h00);
    rd_arr("R7 page0 cleared", 16'h0012, 8'h00);
    rd_arr("R7 page1 cleared", 16'h0134, 8'h00);
    rd_arr("R7 last entry cleared", 16'h01FF, 8'h00);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_zero_page();
    t_stack();
    t_ram();
    t_reset_keep();
    t_clear();
    @(negedge clk); idle();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule